// File: doc/BRIEF.md
# Inter-Processor Mailbox with Per-User Interrupts

This peripheral lets several processors pass 32-bit words to one another through a set of small hardware queues, called mailboxes. Any processor may store a word into a mailbox by writing that mailbox's message register. Any processor may take the oldest word out by reading the same register. Each mailbox reports two things on read-only registers: whether it is full, with a sticky flag for a dropped write, and how many words it holds.

Each user, meaning a processor that receives interrupts, owns a status register and an enable register. Every accepted store into a mailbox raises that mailbox's new-message event in every user's status register. Every read that frees a slot in a full mailbox raises that mailbox's not-full event. A user clears events by writing ones to its status register. Its interrupt line is a registered OR over the status bits that are also enabled.

Access is through a single-cycle register port. One address serves both strobes. Read data is a combinational function of the address and the current state. A write or a dequeue takes effect at the clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every mailbox is empty with its overflow flag clear. Every user status and enable register reads zero, the configuration register reads zero, and every interrupt output is low.
- R2: The message register of mailbox m is at byte offset 0x040+4m. A write stores a word and a read returns and removes the oldest stored word (first in, first out). A read of an empty mailbox returns zero and changes nothing.
- R3: The count register of mailbox m is at 0x0C0+4m and returns the number of stored words, where zero means empty.
- R4: The full register of mailbox m is at 0x080+4m. Bit 0 is 1 while the mailbox holds DEPTH words. Bit 1 is a sticky overflow flag, cleared only by reset. A write to a full mailbox with no read in the same cycle is dropped and sets that flag.
- R5: Each accepted store into mailbox m sets bit 2m of every user's status register. User u's status register is at 0x100+8u.
- R6: A read that takes mailbox m from full to not full, with no store in the same cycle, sets bit 2m+1 of every user's status register.
- R7: Writing a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. An event arriving in the same cycle as its clear wins.
- R8: User u's enable register at 0x104+8u reads back what was written. Interrupt output u is, one clock after any state, the OR of (status AND enable) for that user as it stood in that state.
- R9: Read and write strobes together on a message register return the oldest word, remove it and store the new word in one cycle. On a full mailbox the store is accepted, the count stays at DEPTH, and neither overflow nor not-full is raised. On an empty mailbox the read returns zero and the count becomes one.
- R10: Offset 0x000 returns the version, with the major number in bits 7:4 and the minor number in bits 3:0. Offset 0x010 keeps only bits 0 and 4 of a write, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_re | input | 1 | Read strobe; dequeues when aimed at a message register |
| bus_rdata | output | DATA_W (32) | Contents of the addressed register |
| irq_out | output | NUM_USER (4) | One registered interrupt line per user |

## Verification
A dequeue and an enqueue on the same mailbox can fall in the same cycle. This happens when both strobes are raised on one message register. The bench provokes it at random and, in directed steps, on a full and on an empty mailbox. A reference model applies the pop before the push and predicts the returned word, the count, the overflow flag and the events. The bench then judges that a full mailbox stays full without overflow or a not-full event, and that an empty one returns zero and ends holding the new word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned OFS_VERSION = 32'h000;
  localparam int unsigned OFS_CONFIG  = 32'h010;
  localparam int unsigned OFS_MSG     = 32'h040;
  localparam int unsigned OFS_FULL    = 32'h080;
  localparam int unsigned OFS_COUNT   = 32'h0C0;
  localparam int unsigned OFS_USER    = 32'h100;
  localparam logic [31:0] CONFIG_KEEP = 32'h0000_0011;

  function automatic int unsigned msg_ofs(int unsigned m);
    return OFS_MSG + 4 * m;
  endfunction

  function automatic int unsigned full_ofs(int unsigned m);
    return OFS_FULL + 4 * m;
  endfunction

  function automatic int unsigned count_ofs(int unsigned m);
    return OFS_COUNT + 4 * m;
  endfunction

  function automatic int unsigned status_ofs(int unsigned u);
    return OFS_USER + 8 * u;
  endfunction

  function automatic int unsigned enable_ofs(int unsigned u);
    return OFS_USER + 8 * u + 4;
  endfunction

  function automatic int unsigned newmsg_bit(int unsigned m);
    return 2 * m;
  endfunction

  function automatic int unsigned notfull_bit(int unsigned m);
    return 2 * m + 1;
  endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              push_ok,
  output logic              left_full,
  output logic              ovf
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic              empty, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign pop_ok    = pop_req && !empty;
  assign push_ok   = push_req && (!full || pop_ok);
  assign left_full = pop_ok && full && !push_req;
  assign head      = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (push_req && !push_ok) ovf <= 1'b1;
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R4
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> ($stable(count) && ovf));

  // R2
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> (count == '0));

  // R9
  swap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && full) |=> (full && $stable(ovf)));

  // R6
  left_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    left_full |=> !full);

endmodule

// File: rtl/mbx_user.sv
module mbx_user #(
  parameter int EVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] evt_set,
  input  logic           ack_we,
  input  logic [EVW-1:0] ack_mask,
  input  logic           en_we,
  input  logic [EVW-1:0] en_wdata,
  output logic [EVW-1:0] status,
  output logic [EVW-1:0] enable,
  output logic           irq
);

  logic [EVW-1:0] clr_bits;
  logic [EVW-1:0] status_nxt;

  assign clr_bits   = ack_we ? ack_mask : '0;
  assign status_nxt = (status & ~clr_bits) | evt_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nxt;
      if (en_we) enable <= en_wdata;
      irq <= |(status & enable);
    end
  end

  // R5
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((status & $past(evt_set)) == $past(evt_set)));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ((ack_mask & evt_set) == '0)) |=> ((status & $past(ack_mask)) == '0));

  // R7
  zero_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((status & $past(status) & ~$past(ack_mask)) == ($past(status) & ~$past(ack_mask))));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |=> !irq);

  // R8
  irq_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status & enable)) |=> irq);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 12,
  parameter int          NUM_BOX   = 4,
  parameter int          NUM_USER  = 4,
  parameter int          DEPTH     = 4,
  parameter logic [3:0]  REV_MAJOR = 4'd2,
  parameter logic [3:0]  REV_MINOR = 4'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_USER-1:0] irq_out
);

  localparam int EVW   = 2 * NUM_BOX;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [NUM_BOX-1:0]  hit_msg, hit_full, hit_cnt;
  logic [NUM_USER-1:0] hit_sts, hit_en;
  logic                hit_ver, hit_cfg;

  logic [DATA_W-1:0] box_head [NUM_BOX];
  logic [CNT_W-1:0]  box_cnt  [NUM_BOX];
  logic [NUM_BOX-1:0] box_full, box_push_ok, box_left_full, box_ovf;
  logic [EVW-1:0]    evt_vec;

  logic [EVW-1:0] usr_status [NUM_USER];
  logic [EVW-1:0] usr_enable [NUM_USER];

  logic [DATA_W-1:0] cfg_q;

  assign hit_ver = (bus_addr == ADDR_W'(OFS_VERSION));
  assign hit_cfg = (bus_addr == ADDR_W'(OFS_CONFIG));

  for (genvar m = 0; m < NUM_BOX; m++) begin : g_box
    assign hit_msg[m]  = (bus_addr == ADDR_W'(msg_ofs(m)));
    assign hit_full[m] = (bus_addr == ADDR_W'(full_ofs(m)));
    assign hit_cnt[m]  = (bus_addr == ADDR_W'(count_ofs(m)));

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (bus_we && hit_msg[m]),
      .pop_req   (bus_re && hit_msg[m]),
      .wdata     (bus_wdata),
      .head      (box_head[m]),
      .count     (box_cnt[m]),
      .full      (box_full[m]),
      .push_ok   (box_push_ok[m]),
      .left_full (box_left_full[m]),
      .ovf       (box_ovf[m])
    );

    assign evt_vec[newmsg_bit(m)]  = box_push_ok[m];
    assign evt_vec[notfull_bit(m)] = box_left_full[m];
  end

  for (genvar u = 0; u < NUM_USER; u++) begin : g_user
    assign hit_sts[u] = (bus_addr == ADDR_W'(status_ofs(u)));
    assign hit_en[u]  = (bus_addr == ADDR_W'(enable_ofs(u)));

    mbx_user #(.EVW(EVW)) i_user (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_set  (evt_vec),
      .ack_we   (bus_we && hit_sts[u]),
      .ack_mask (bus_wdata[EVW-1:0]),
      .en_we    (bus_we && hit_en[u]),
      .en_wdata (bus_wdata[EVW-1:0]),
      .status   (usr_status[u]),
      .enable   (usr_enable[u]),
      .irq      (irq_out[u])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (bus_we && hit_cfg) cfg_q <= bus_wdata & DATA_W'(CONFIG_KEEP);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ver) bus_rdata = DATA_W'({REV_MAJOR, REV_MINOR});
    if (hit_cfg) bus_rdata = cfg_q;
    for (int m = 0; m < NUM_BOX; m++) begin
      if (hit_msg[m])  bus_rdata = box_head[m];
      if (hit_full[m]) bus_rdata = DATA_W'({box_ovf[m], box_full[m]});
      if (hit_cnt[m])  bus_rdata = DATA_W'(box_cnt[m]);
    end
    for (int u = 0; u < NUM_USER; u++) begin
      if (hit_sts[u]) bus_rdata = DATA_W'(usr_status[u]);
      if (hit_en[u])  bus_rdata = DATA_W'(usr_enable[u]);
    end
  end

  // R10
  cfg_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~DATA_W'(CONFIG_KEEP)) == '0);

  // R1
  irq_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_out == '0));

endmodule

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;

  localparam int NB = 4;
  localparam int NU = 4;
  localparam int DP = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we, re;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  irq;

  always #2.5 clk = ~clk;

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_re(re), .bus_rdata(rdata), .irq_out(irq)
  );

  int unsigned vectors = 0;
  int unsigned errors  = 0;
  bit          done    = 1'b0;

  logic [31:0] mq   [NB][DP];
  int          mcnt [NB];
  bit          movf [NB];
  logic [7:0]  mstat[NU];
  logic [7:0]  men  [NU];
  logic [3:0]  mirq;
  logic [31:0] mcfg;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    if (a == 12'h000) return 32'h20;
    if (a == 12'h010) return mcfg;
    for (int m = 0; m < NB; m++) begin
      if (a == 12'h040 + 12'(4*m)) return (mcnt[m] > 0) ? mq[m][0] : 32'h0;
      if (a == 12'h080 + 12'(4*m)) return {30'h0, movf[m], mcnt[m] == DP};
      if (a == 12'h0C0 + 12'(4*m)) return 32'(mcnt[m]);
    end
    for (int u = 0; u < NU; u++) begin
      if (a == 12'h100 + 12'(8*u)) return {24'h0, mstat[u]};
      if (a == 12'h104 + 12'(8*u)) return {24'h0, men[u]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (a == 12'h000 || a == 12'h010) return "R10";
    if (a >= 12'h040 && a < 12'h080) return "R2";
    if (a >= 12'h080 && a < 12'h0C0) return "R4";
    if (a >= 12'h0C0 && a < 12'h100) return "R3";
    if (a >= 12'h100 && a[2] == 1'b0) return "R5";
    if (a >= 12'h100) return "R8";
    return "R10";
  endfunction

  task automatic model_step(logic [11:0] a, bit w, logic [31:0] d, bit r);
    logic [7:0] evts = 8'h0;
    for (int u = 0; u < NU; u++) mirq[u] = |(mstat[u] & men[u]);
    for (int m = 0; m < NB; m++) begin
      if (a == 12'h040 + 12'(4*m)) begin
        bit was_full = (mcnt[m] == DP);
        bit popped   = r && (mcnt[m] > 0);
        if (popped) begin
          for (int i = 0; i < DP - 1; i++) mq[m][i] = mq[m][i+1];
          mcnt[m]--;
        end
        if (w && (!was_full || popped)) begin
          mq[m][mcnt[m]] = d;
          mcnt[m]++;
          evts[2*m] = 1'b1;
        end else if (w) begin
          movf[m] = 1'b1;
        end
        if (popped && was_full && !w) evts[2*m+1] = 1'b1;
      end
    end
    if (w && a == 12'h010) mcfg = d & 32'h11;
    for (int u = 0; u < NU; u++) begin
      if (w && a == 12'h100 + 12'(8*u)) mstat[u] = mstat[u] & ~d[7:0];
      if (w && a == 12'h104 + 12'(8*u)) men[u] = d[7:0];
      mstat[u] = mstat[u] | evts;
    end
  endtask

  task automatic op(logic [11:0] a, bit w, logic [31:0] d, bit r, string tag = "");
    @(negedge clk);
    addr = a; we = w; wdata = d; re = r;
    #1;
    if (r) check((tag == "") ? tag_of(a) : tag, rdata, model_read(a));
    model_step(a, w, d, r);
    @(posedge clk);
    #1;
    check("R8", {28'h0, irq}, {28'h0, mirq});
    we = 1'b0; re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int m = 0; m < NB; m++) begin
      mcnt[m] = 0; movf[m] = 1'b0;
      for (int i = 0; i < DP; i++) mq[m][i] = '0;
    end
    for (int u = 0; u < NU; u++) begin mstat[u] = '0; men[u] = '0; end
    mirq = '0; mcfg = '0;
  endtask

  function automatic logic [11:0] rand_reg();
    case ($urandom_range(0, 6))
      0: return 12'h080 + 12'(4 * $urandom_range(0, NB-1));
      1: return 12'h0C0 + 12'(4 * $urandom_range(0, NB-1));
      2: return 12'h100 + 12'(8 * $urandom_range(0, NU-1));
      3: return 12'h104 + 12'(8 * $urandom_range(0, NU-1));
      4: return 12'h000;
      5: return 12'h010;
      default: return 12'h024;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    do_reset();
    #1;
    check("R1", {28'h0, irq}, 32'h0);
    // R1: every register at its reset value
    for (int m = 0; m < NB; m++) begin
      op(12'h080 + 12'(4*m), 0, 0, 1, "R1");
      op(12'h0C0 + 12'(4*m), 0, 0, 1, "R1");
    end
    for (int u = 0; u < NU; u++) begin
      op(12'h100 + 12'(8*u), 0, 0, 1, "R1");
      op(12'h104 + 12'(8*u), 0, 0, 1, "R1");
    end
    op(12'h010, 0, 0, 1, "R1");
    // R10: version and configuration mask
    op(12'h000, 0, 0, 1, "R10");
    op(12'h010, 1, 32'hFFFF_FFFF, 0);
    op(12'h010, 0, 0, 1, "R10");
    op(12'h0F8, 0, 0, 1, "R10");
    // R2: empty read yields zero and leaves the count
    op(12'h040, 0, 0, 1, "R2");
    op(12'h0C0, 0, 0, 1, "R3");
    // R5/R8: enable user 1 on mailbox 0 new-message
    op(12'h10C, 1, 32'h01, 0);
    op(12'h10C, 0, 0, 1, "R8");
    for (int i = 0; i < DP; i++) op(12'h040, 1, 32'hA000_0000 + 32'(i), 0);
    op(12'h110, 0, 0, 1, "R5");
    op(12'h080, 0, 0, 1, "R4");
    // R4: drop on full and sticky overflow
    op(12'h040, 1, 32'hDEAD_BEEF, 0);
    op(12'h080, 0, 0, 1, "R4");
    op(12'h0C0, 0, 0, 1, "R3");
    // R7: zero leaves, one clears
    op(12'h100, 1, 32'h0, 0);
    op(12'h100, 0, 0, 1, "R7");
    op(12'h100, 1, 32'h1, 0);
    op(12'h100, 0, 0, 1, "R7");
    // R9: simultaneous on full mailbox
    op(12'h040, 1, 32'h5555_AAAA, 1, "R9");
    op(12'h0C0, 0, 0, 1, "R9");
    op(12'h100, 0, 0, 1, "R9");
    op(12'h080, 0, 0, 1, "R9");
    // R6: pop from full raises not-full
    op(12'h040, 0, 0, 1, "R2");
    op(12'h108, 0, 0, 1, "R6");
    op(12'h118, 0, 0, 1, "R6");
    // R9: simultaneous on empty mailbox 1
    op(12'h044, 1, 32'h1234_5678, 1, "R9");
    op(12'h0C4, 0, 0, 1, "R9");
    op(12'h044, 0, 0, 1, "R2");
    // drain mailbox 0 in order
    for (int i = 0; i < DP; i++) op(12'h040, 0, 0, 1, "R2");

    // constrained random traffic
    for (int n = 0; n < 6000; n++) begin
      int k = $urandom_range(0, 11);
      logic [11:0] mb = 12'h040 + 12'(4 * $urandom_range(0, NB-1));
      case (k)
        0, 1, 2: op(mb, 1, $urandom, 0);
        3, 4:    op(mb, 0, 0, 1);
        5:       op(mb, 1, $urandom, 1, "R9");
        6, 7:    op(rand_reg(), 0, 0, 1);
        8:       op(12'h100 + 12'(8 * $urandom_range(0, NU-1)), 1, $urandom, 0);
        9:       op(12'h104 + 12'(8 * $urandom_range(0, NU-1)), 1, $urandom, 0);
        10:      op(12'h100 + 12'(8 * $urandom_range(0, NU-1)), 1, $urandom, 1, "R7");
        default: op(12'h024, $urandom_range(0, 1) == 1, $urandom, 1, "R10");
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule